// File: doc/BRIEF.md
# Packet Header Interpreter and Command Executor

This block is the protocol controller of one link channel. It watches the token stream that the channel's receiver delivers. Each token is either a data byte or an end-of-packet marker. In protocol mode, the first four data bytes after an end-of-packet marker (or after reset) form a header. Byte 0 is the destination address, byte 1 is a command code, and bytes 2–3 are a parameter. Only byte 2 is used, as an index. Each header byte is also presented on a side output, so that an acknowledge stage can copy it.

Once the fourth header byte arrives, the block makes one of three decisions:

- It opens the payload path to the receive FIFO.
- It performs a simple control action: drive the CPU reset line, drive an external control line, or pulse the reset of one link or all links.
- It raises a one-cycle error flag and discards the rest of the packet.

Actions that could disturb the system are guarded by an arming flag. An arm command must set this flag beforehand, and the flag is consumed by the first guarded action that executes.

In transparent and routing modes the interpreter stands aside. Every data byte goes straight to the FIFO output.

Top module: `pkt_cmd_ctrl`

## Requirements
- R1: After reset, all outputs are low. The arming flag is clear, and the next data byte is treated as header byte 0.
- R2: In protocol mode (mode 2), the four data bytes after an end-of-packet marker or after reset are header bytes. They appear on `hdr_valid_o`/`hdr_idx_o` (0..3)/`hdr_byte_o` in the following cycle and are never forwarded.
- R3: A header with a matching address and code 0x01 forwards each later data byte on `fwd_valid_o`/`fwd_data_o` in the following cycle, until the next end-of-packet marker. End-of-packet markers are never forwarded.
- R4: If header byte 0 differs from `chan_addr_i`, only `err_o` bit 0 pulses for one cycle. The payload is dropped and no action takes place. At most one error bit is ever set.
- R5: A code outside the table, or an index in byte 2 at or beyond the number of lines or links, pulses `err_o` bit 1 and causes no action.
- R6: Code 0x5A sets the arming flag. A guarded action that executes clears the flag, so a second guarded action needs a new arm.
- R7: A guarded code (0xC1, 0xE1, 0xE2) received while the flag is clear pulses `err_o` bit 2. The CPU reset line and the link resets stay unchanged.
- R8: Code 0xC1 (guarded) drives `cpu_rst_o` high. Code 0xC0 (not guarded) drives it low.
- R9: Code 0x31 sets `ext_sig_o[byte 2]` and code 0x30 clears it. Neither code is guarded.
- R10: Code 0xE1 pulses `link_rst_o[byte 2]` for one cycle, and code 0xE2 pulses every bit. Both codes are guarded.
- R11: An end-of-packet marker after one to three header bytes pulses `err_o` bit 3. An end-of-packet marker right after another one is ignored.
- R12: In modes 0, 1 and 3, every data byte is forwarded in the following cycle. No header is taken and no error is raised. On return to mode 2, the next data byte is header byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | 0 transparent, 1 routing, 2 protocol, 3 treated as bypass |
| chan_addr_i | input | 8 | Address of this channel |
| tok_valid_i | input | 1 | A token is present this cycle |
| tok_eop_i | input | 1 | The token is an end-of-packet marker |
| tok_data_i | input | 8 | Data byte of the token |
| fwd_valid_o | output | 1 | Payload byte for the receive FIFO |
| fwd_data_o | output | 8 | Payload byte value |
| hdr_valid_o | output | 1 | Header byte strobe for the acknowledge stage |
| hdr_idx_o | output | 2 | Position of the header byte |
| hdr_byte_o | output | 8 | Header byte value |
| cpu_rst_o | output | 1 | CPU reset line (high = asserted) |
| ext_sig_o | output | NEXT | External control lines |
| link_rst_o | output | NLINK | One-cycle link reset pulses |
| err_o | output | 4 | Error pulses: bit0 address, bit1 command, bit2 not armed, bit3 short header |

## Verification
The bench builds the block with NLINK=4 and NEXT=2, instead of the defaults 3 and 4. This makes the index boundaries asymmetric. Index 3 is a legal link while index 2 is already an illegal line, which catches an implementation that confuses the two limits. The small line count also makes the out-of-range index case for external lines cheap to reach. The all-links pulse is checked as a four-bit mask, so a loop bound fixed at three would show up.

// File: rtl/pkt_cmd_pkg.sv
// Shared codes and types of the packet header interpreter.
// Assumes a fixed four-byte header: address, command, index, spare.
package pkt_cmd_pkg;
    localparam int HDR_BYTES = 4;
    localparam int ERR_W     = 4;
    localparam int ERR_ADDR  = 0;
    localparam int ERR_CMD   = 1;
    localparam int ERR_LOCK  = 2;
    localparam int ERR_SHORT = 3;

    localparam logic [1:0] MODE_PROTO = 2'd2;

    localparam logic [7:0] OP_DATA     = 8'h01;
    localparam logic [7:0] OP_ARM      = 8'h5A;
    localparam logic [7:0] OP_CPU_ON   = 8'hC1;
    localparam logic [7:0] OP_CPU_OFF  = 8'hC0;
    localparam logic [7:0] OP_EXT_SET  = 8'h31;
    localparam logic [7:0] OP_EXT_CLR  = 8'h30;
    localparam logic [7:0] OP_LINK_ONE = 8'hE1;
    localparam logic [7:0] OP_LINK_ALL = 8'hE2;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_DATA, ACT_ARM, ACT_CPU_ON, ACT_CPU_OFF,
        ACT_EXT_SET, ACT_EXT_CLR, ACT_LINK_ONE, ACT_LINK_ALL
    } act_e;

    typedef struct packed {
        act_e       act;
        logic       guarded;
        logic       bad_addr;
        logic       bad_cmd;
        logic [7:0] arg;
    } verdict_t;
endpackage

// File: rtl/pkt_hdr_collect.sv
// Header collector: counts data bytes after each end-of-packet marker,
// keeps the first three header bytes and flags the fourth as "done".
// It drives the header side output and reports headers cut short.
// Assumes at most one token per cycle; the count is held at zero
// outside protocol mode.
module pkt_hdr_collect
    import pkt_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proto,
    input  logic       tok_valid,
    input  logic       tok_eop,
    input  logic [7:0] tok_data,
    output logic       hdr_done,
    output logic       in_payload,
    output logic       short_eop,
    output logic [7:0] hdr_addr,
    output logic [7:0] hdr_cmd,
    output logic [7:0] hdr_arg,
    output logic       hdr_valid,
    output logic [1:0] hdr_idx,
    output logic [7:0] hdr_byte
);
    localparam int CNT_W  = $clog2(HDR_BYTES + 1);
    localparam int KEEP_W = 8 * (HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HDR_BYTES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [KEEP_W-1:0] keep_q;
    logic              take_hdr;

    assign take_hdr   = proto && tok_valid && !tok_eop && (cnt_q != CNT_FULL);
    assign hdr_done   = take_hdr && (cnt_q == CNT_LAST);
    assign in_payload = (cnt_q == CNT_FULL);
    assign short_eop  = proto && tok_valid && tok_eop
                        && (cnt_q != '0) && (cnt_q != CNT_FULL);
    assign hdr_addr   = keep_q[KEEP_W-1 -: 8];
    assign hdr_cmd    = keep_q[KEEP_W-9 -: 8];
    assign hdr_arg    = keep_q[7:0];

    // Byte counter: restarts on end-of-packet, saturates in the payload.
    always_ff @(posedge clk) begin
        if (!rst_n || !proto)
            cnt_q <= '0;
        else if (tok_valid && tok_eop)
            cnt_q <= '0;
        else if (take_hdr)
            cnt_q <= cnt_q + 1'b1;
    end

    // Header store: shifts in the bytes that precede the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            keep_q <= '0;
        else if (take_hdr && !hdr_done)
            keep_q <= {keep_q[KEEP_W-9:0], tok_data};
    end

    // Side output for the acknowledge stage, one cycle after the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_valid <= 1'b0;
            hdr_idx   <= '0;
            hdr_byte  <= '0;
        end else begin
            hdr_valid <= take_hdr;
            hdr_idx   <= cnt_q[1:0];
            hdr_byte  <= tok_data;
        end
    end
endmodule

// File: rtl/pkt_cmd_decode.sv
// Command decoder: pure logic that classifies a completed header.
// Checks the address, maps the code to an action, marks guarded
// actions and rejects indices beyond the number of lines or links.
module pkt_cmd_decode
    import pkt_cmd_pkg::*;
#(
    parameter int NLINK = 3,
    parameter int NEXT  = 4
) (
    input  logic [7:0] chan_addr,
    input  logic [7:0] hdr_addr,
    input  logic [7:0] hdr_cmd,
    input  logic [7:0] hdr_arg,
    output verdict_t   verdict
);
    localparam logic [8:0] LINK_LIM = 9'(NLINK);
    localparam logic [8:0] EXT_LIM  = 9'(NEXT);

    logic link_ok;
    logic ext_ok;

    assign link_ok = {1'b0, hdr_arg} < LINK_LIM;
    assign ext_ok  = {1'b0, hdr_arg} < EXT_LIM;

    // Code table lookup with index range checks.
    always_comb begin
        verdict          = '0;
        verdict.arg      = hdr_arg;
        verdict.bad_addr = (hdr_addr != chan_addr);
        verdict.act      = ACT_NONE;
        verdict.bad_cmd  = 1'b0;
        unique case (hdr_cmd)
            OP_DATA:    verdict.act = ACT_DATA;
            OP_ARM:     verdict.act = ACT_ARM;
            OP_CPU_OFF: verdict.act = ACT_CPU_OFF;
            OP_CPU_ON: begin
                verdict.act     = ACT_CPU_ON;
                verdict.guarded = 1'b1;
            end
            OP_EXT_SET: begin
                verdict.act     = ext_ok ? ACT_EXT_SET : ACT_NONE;
                verdict.bad_cmd = !ext_ok;
            end
            OP_EXT_CLR: begin
                verdict.act     = ext_ok ? ACT_EXT_CLR : ACT_NONE;
                verdict.bad_cmd = !ext_ok;
            end
            OP_LINK_ONE: begin
                verdict.act     = link_ok ? ACT_LINK_ONE : ACT_NONE;
                verdict.bad_cmd = !link_ok;
                verdict.guarded = link_ok;
            end
            OP_LINK_ALL: begin
                verdict.act     = ACT_LINK_ALL;
                verdict.guarded = 1'b1;
            end
            default:    verdict.bad_cmd = 1'b1;
        endcase
    end
endmodule

// File: rtl/pkt_cmd_exec.sv
// Command executor: holds the arming flag, the CPU reset and external
// line levels, produces link reset pulses and the error pulses.
// Errors are ranked address, then command, then not armed, so at most
// one bit is set; a short header can never coincide with a verdict.
module pkt_cmd_exec
    import pkt_cmd_pkg::*;
#(
    parameter int NLINK = 3,
    parameter int NEXT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  verdict_t         verdict,
    input  logic             short_eop,
    output logic             go,
    output logic             cpu_rst,
    output logic [NEXT-1:0]  ext_sig,
    output logic [NLINK-1:0] link_rst,
    output logic [ERR_W-1:0] err
);
    logic armed_q;
    logic hdr_ok;
    logic locked;

    assign hdr_ok = fire && !verdict.bad_addr && !verdict.bad_cmd;
    assign locked = hdr_ok && verdict.guarded && !armed_q;
    assign go     = hdr_ok && !locked;

    // Arming flag: set by the arm code, consumed by a guarded action.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (go && verdict.guarded)
            armed_q <= 1'b0;
        else if (go && verdict.act == ACT_ARM)
            armed_q <= 1'b1;
    end

    // CPU reset level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_rst <= 1'b0;
        else if (go && verdict.act == ACT_CPU_ON)
            cpu_rst <= 1'b1;
        else if (go && verdict.act == ACT_CPU_OFF)
            cpu_rst <= 1'b0;
    end

    // One-cycle error pulses, ranked so that a single bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= '0;
        end else begin
            err            <= '0;
            err[ERR_ADDR]  <= fire && verdict.bad_addr;
            err[ERR_CMD]   <= fire && !verdict.bad_addr && verdict.bad_cmd;
            err[ERR_LOCK]  <= locked;
            err[ERR_SHORT] <= short_eop;
        end
    end

    for (genvar gi = 0; gi < NEXT; gi++) begin : g_ext
        // External line gi: set or cleared by an indexed command.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ext_sig[gi] <= 1'b0;
            else if (go && verdict.arg == 8'(gi) && verdict.act == ACT_EXT_SET)
                ext_sig[gi] <= 1'b1;
            else if (go && verdict.arg == 8'(gi) && verdict.act == ACT_EXT_CLR)
                ext_sig[gi] <= 1'b0;
        end
    end

    for (genvar gl = 0; gl < NLINK; gl++) begin : g_link
        // Link gl reset pulse: its own index or the all-links code.
        always_ff @(posedge clk) begin
            if (!rst_n)
                link_rst[gl] <= 1'b0;
            else
                link_rst[gl] <= go && ((verdict.act == ACT_LINK_ALL)
                              || (verdict.act == ACT_LINK_ONE && verdict.arg == 8'(gl)));
        end
    end
endmodule

// File: rtl/pkt_cmd_ctrl.sv
// Per-channel protocol controller top. In protocol mode it interprets a
// four-byte header after every end-of-packet marker and either opens the
// payload path or runs a control command; in the other modes every data
// byte passes straight through. All outputs are registered.
module pkt_cmd_ctrl
    import pkt_cmd_pkg::*;
#(
    parameter int NLINK = 3,
    parameter int NEXT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [7:0]       chan_addr_i,
    input  logic             tok_valid_i,
    input  logic             tok_eop_i,
    input  logic [7:0]       tok_data_i,
    output logic             fwd_valid_o,
    output logic [7:0]       fwd_data_o,
    output logic             hdr_valid_o,
    output logic [1:0]       hdr_idx_o,
    output logic [7:0]       hdr_byte_o,
    output logic             cpu_rst_o,
    output logic [NEXT-1:0]  ext_sig_o,
    output logic [NLINK-1:0] link_rst_o,
    output logic [ERR_W-1:0] err_o
);
    logic       proto;
    logic       hdr_done;
    logic       in_payload;
    logic       short_eop;
    logic [7:0] hdr_addr;
    logic [7:0] hdr_cmd;
    logic [7:0] hdr_arg;
    logic       go;
    logic       pass_q;
    verdict_t   verdict;

    assign proto = (mode_i == MODE_PROTO);

    pkt_hdr_collect u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .proto      (proto),
        .tok_valid  (tok_valid_i),
        .tok_eop    (tok_eop_i),
        .tok_data   (tok_data_i),
        .hdr_done   (hdr_done),
        .in_payload (in_payload),
        .short_eop  (short_eop),
        .hdr_addr   (hdr_addr),
        .hdr_cmd    (hdr_cmd),
        .hdr_arg    (hdr_arg),
        .hdr_valid  (hdr_valid_o),
        .hdr_idx    (hdr_idx_o),
        .hdr_byte   (hdr_byte_o)
    );

    pkt_cmd_decode #(.NLINK(NLINK), .NEXT(NEXT)) u_decode (
        .chan_addr (chan_addr_i),
        .hdr_addr  (hdr_addr),
        .hdr_cmd   (hdr_cmd),
        .hdr_arg   (hdr_arg),
        .verdict   (verdict)
    );

    pkt_cmd_exec #(.NLINK(NLINK), .NEXT(NEXT)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (hdr_done),
        .verdict   (verdict),
        .short_eop (short_eop),
        .go        (go),
        .cpu_rst   (cpu_rst_o),
        .ext_sig   (ext_sig_o),
        .link_rst  (link_rst_o),
        .err       (err_o)
    );

    // Payload gate: opened by an accepted data header, closed by the marker.
    always_ff @(posedge clk) begin
        if (!rst_n || !proto)
            pass_q <= 1'b0;
        else if (tok_valid_i && tok_eop_i)
            pass_q <= 1'b0;
        else if (hdr_done)
            pass_q <= go && (verdict.act == ACT_DATA);
    end

    // Forwarded byte toward the receive FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid_o <= 1'b0;
            fwd_data_o  <= '0;
        end else begin
            fwd_valid_o <= tok_valid_i && !tok_eop_i
                           && (!proto || (in_payload && pass_q));
            fwd_data_o  <= tok_data_i;
        end
    end
endmodule

// File: rtl/pkt_cmd_ctrl_chk.sv
// Checker for pkt_cmd_ctrl: port-level temporal properties, bound below.
module pkt_cmd_ctrl_chk #(
    parameter int NLINK = 3,
    parameter int NEXT  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             tok_valid_i,
    input logic             tok_eop_i,
    input logic             fwd_valid_o,
    input logic             hdr_valid_o,
    input logic             cpu_rst_o,
    input logic [NEXT-1:0]  ext_sig_o,
    input logic [NLINK-1:0] link_rst_o,
    input logic [3:0]       err_o
);
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_o)); // R4

    AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && mode_i != 2'd2) |=> (!hdr_valid_o && err_o == 4'd0)); // R12

    AST_EOP_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_eop_i) |=> !fwd_valid_o); // R3

    AST_HDR_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> !fwd_valid_o); // R2

    AST_LOCK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o[2] |-> (link_rst_o == '0 && $stable(cpu_rst_o))); // R7

    AST_LINK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rst_o != '0) |=> (link_rst_o == '0)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid_i |=> (err_o == 4'd0 && !hdr_valid_o && !fwd_valid_o
                          && link_rst_o == '0 && $stable(ext_sig_o))); // R9
endmodule

bind pkt_cmd_ctrl pkt_cmd_ctrl_chk #(.NLINK(NLINK), .NEXT(NEXT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .tok_valid_i (tok_valid_i),
    .tok_eop_i   (tok_eop_i),
    .fwd_valid_o (fwd_valid_o),
    .hdr_valid_o (hdr_valid_o),
    .cpu_rst_o   (cpu_rst_o),
    .ext_sig_o   (ext_sig_o),
    .link_rst_o  (link_rst_o),
    .err_o       (err_o)
);

// File: tb/tb_pkt_cmd_ctrl.sv
// Scoreboard bench: the driver predicts each output event from the
// requirements and queues it; the monitor pops and compares.
module tb_pkt_cmd_ctrl;
    localparam int NLINK = 4;
    localparam int NEXT  = 2;
    localparam logic [7:0] CH = 8'h42;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = 2'd2;
    logic [7:0]       chan_addr_i = CH;
    logic             tok_valid_i = 1'b0;
    logic             tok_eop_i = 1'b0;
    logic [7:0]       tok_data_i = 8'h00;
    logic             fwd_valid_o;
    logic [7:0]       fwd_data_o;
    logic             hdr_valid_o;
    logic [1:0]       hdr_idx_o;
    logic [7:0]       hdr_byte_o;
    logic             cpu_rst_o;
    logic [NEXT-1:0]  ext_sig_o;
    logic [NLINK-1:0] link_rst_o;
    logic [3:0]       err_o;

    always #2 clk = ~clk;

    pkt_cmd_ctrl #(.NLINK(NLINK), .NEXT(NEXT)) dut (.*);

    typedef struct { int kind; int val; string req; } exp_t;
    localparam int K_HDR = 0, K_FWD = 1, K_ERR = 2, K_LNK = 3;
    exp_t q[$];

    int vectors = 0;
    int fails   = 0;
    bit running = 1'b0;

    // Reference state kept from the requirements.
    int               m_cnt = 0;
    logic [7:0]       m_hdr [4];
    bit               m_pass = 0;
    bit               m_armed = 0;
    logic             m_cpu = 0;
    logic [NEXT-1:0]  m_ext = '0;

    task automatic push(int k, int v, string r);
        exp_t e;
        e.kind = k; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    task automatic compare(int k, int v);
        exp_t e;
        vectors++;
        if (q.size() == 0) begin
            fails++;
            $display("FAIL unexpected event kind %0d: actual %0h expected none", k, v);
        end else begin
            e = q.pop_front();
            if (e.kind != k || e.val != v) begin
                fails++;
                $display("FAIL %s: actual kind %0d val %0h expected kind %0d val %0h",
                         e.req, k, v, e.kind, e.val);
            end
        end
    endtask

    // Monitor: compares every active output against the queue.
    always @(negedge clk) begin
        if (running) begin
            if (hdr_valid_o) compare(K_HDR, {hdr_idx_o, hdr_byte_o});
            if (fwd_valid_o) compare(K_FWD, int'(fwd_data_o));
            if (err_o != 4'd0) compare(K_ERR, int'(err_o));
            if (link_rst_o != '0) compare(K_LNK, int'(link_rst_o));
        end
    end

    task automatic guarded_run(logic [7:0] cmd, logic [7:0] arg);
        if (!m_armed) begin
            push(K_ERR, 4, "R7");
        end else begin
            m_armed = 0;
            if (cmd == 8'hC1) m_cpu = 1'b1;                       // R8
            else if (cmd == 8'hE1) push(K_LNK, 1 << arg, "R10");
            else push(K_LNK, (1 << NLINK) - 1, "R10");
        end
    endtask

    task automatic judge();
        logic [7:0] a, c, g;
        a = m_hdr[0]; c = m_hdr[1]; g = m_hdr[2];
        if (a != CH) begin
            push(K_ERR, 1, "R4");
        end else begin
            case (c)
                8'h01: m_pass = 1;
                8'h5A: m_armed = 1;                               // R6
                8'hC0: m_cpu = 1'b0;
                8'hC1: guarded_run(c, g);
                8'h31, 8'h30: begin
                    if (g < NEXT) m_ext[g] = (c == 8'h31);        // R9
                    else push(K_ERR, 2, "R5");
                end
                8'hE1: begin
                    if (g < NLINK) guarded_run(c, g);
                    else push(K_ERR, 2, "R5");
                end
                8'hE2: guarded_run(c, g);
                default: push(K_ERR, 2, "R5");
            endcase
        end
    endtask

    // Driver: predict, then present one token for one cycle.
    task automatic send(bit eop, logic [7:0] d);
        if (mode_i != 2'd2) begin
            m_cnt = 0; m_pass = 0;
            if (!eop) push(K_FWD, int'(d), "R12");
        end else if (eop) begin
            if (m_cnt >= 1 && m_cnt <= 3) push(K_ERR, 8, "R11");
            m_cnt = 0; m_pass = 0;
        end else if (m_cnt < 4) begin
            push(K_HDR, (m_cnt << 8) | int'(d), "R2");
            m_hdr[m_cnt] = d;
            if (m_cnt == 3) judge();
            m_cnt++;
        end else if (m_pass) begin
            push(K_FWD, int'(d), "R3");
        end
        tok_valid_i = 1'b1; tok_eop_i = eop; tok_data_i = d;
        @(negedge clk);
        tok_valid_i = 1'b0; tok_eop_i = 1'b0;
    endtask

    task automatic pkt(logic [7:0] a, logic [7:0] c, logic [7:0] g, int n);
        send(0, a); send(0, c); send(0, g); send(0, 8'h00);
        for (int i = 0; i < n; i++) send(0, 8'hA0 + 8'(i));
        send(1, 8'h00);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_lvl(string r);
        vectors++;
        if (cpu_rst_o !== m_cpu || ext_sig_o !== m_ext) begin
            fails++;
            $display("FAIL %s: actual cpu %b ext %b expected cpu %b ext %b",
                     r, cpu_rst_o, ext_sig_o, m_cpu, m_ext);
        end
    endtask

    task automatic finish_run();
        idle(3);
        while (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++; fails++;
            $display("FAIL %s: actual missing expected kind %0d val %0h", e.req, e.kind, e.val);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        vectors++;
        if (fwd_valid_o || hdr_valid_o || cpu_rst_o || ext_sig_o != '0
            || link_rst_o != '0 || err_o != 4'd0) begin
            fails++;
            $display("FAIL R1: actual nonzero outputs expected all low");
        end
        running = 1'b1;

        pkt(CH, 8'h01, 8'h00, 3);            // R2 R3 data packet
        pkt(8'h43, 8'h01, 8'h00, 2);         // R4 address mismatch
        pkt(CH, 8'h77, 8'h00, 1);            // R5 unknown code
        pkt(CH, 8'h31, 8'd2, 0);             // R5 line index out of range
        pkt(CH, 8'hC1, 8'h00, 0);            // R7 not armed
        idle(1); check_lvl("R7");
        pkt(CH, 8'h5A, 8'h00, 2);            // R6 arm, payload dropped
        pkt(CH, 8'hC1, 8'h00, 0);            // R8 cpu reset on
        idle(1); check_lvl("R8");
        pkt(CH, 8'hC1, 8'h00, 0);            // R6 arm consumed
        pkt(CH, 8'hC0, 8'h00, 0);            // R8 release, unguarded
        idle(1); check_lvl("R8");
        pkt(CH, 8'h31, 8'd1, 0);             // R9
        pkt(CH, 8'h31, 8'd0, 0);
        idle(1); check_lvl("R9");
        pkt(CH, 8'h30, 8'd1, 0);
        idle(1); check_lvl("R9");
        pkt(CH, 8'h5A, 8'h00, 0);
        pkt(CH, 8'hE1, 8'd3, 0);             // R10 top link index
        pkt(CH, 8'hE1, 8'd4, 0);             // R5 link index out of range
        pkt(CH, 8'h5A, 8'h00, 0);
        pkt(CH, 8'hE2, 8'h00, 1);            // R10 all links
        send(0, CH); send(0, 8'h01); send(1, 8'h00);   // R11 short header
        send(1, 8'h00);                                  // R11 empty packet
        send(0, CH); send(1, 8'h00);                     // R11 one byte
        pkt(CH, 8'h01, 8'h00, 2);
        idle(2);
        mode_i = 2'd0;                       // R12 transparent
        send(0, 8'h11); send(0, 8'h22); send(1, 8'h00); send(0, 8'h33);
        idle(2);
        mode_i = 2'd1;                       // R12 routing
        send(0, CH); send(0, 8'hC1); send(1, 8'h00);
        idle(2);
        mode_i = 2'd2;                       // R12 back to protocol mid-stream
        pkt(CH, 8'h01, 8'h00, 1);
        idle(1); check_lvl("R12");
        finish_run();
    end
endmodule